// File: doc/BRIEF.md
# Command-Addressed I/O Hub

This block gives a processor access to a few simple peripherals through a single command port. Each access is one strobe carrying an 8-bit command code and an 8-bit payload. The hub decodes the code, performs the side effect that belongs to it, and presents an 8-bit answer on the edge after the strobe. One code both sets what happens and sets what comes back. For example, a transmit request answers with the serial status in the same access.

Behind the command port are three peripherals. The first is a byte-wide serial transmitter that sends 8N1 frames, with the bit period set by a parameter. The second is an 8-bit register that drives the LED pins. The third is a small bank of switch inputs, read through a synchroniser. The serial status also carries one receive-data-valid flag, which enters through its own synchronised pin.

Top module: `io_cmd_hub`

## Requirements
- R1: While reset is held and on release, `rspData` is 0x00, `ledOut` is 0x00, `uartTx` is high and the transmitter is idle.
- R2: Code 0x04 has no side effect and answers with the status byte: bit 0 is transmitter busy, bit 1 is the synchronised receive-valid flag, and bits 7..2 are zero. The status is the one sampled at the command edge.
- R3: Code 0x05 while the transmitter is idle starts a frame with the payload. The frame has a low start bit, then the 8 data bits least significant first, then a high stop bit, each bit lasting CLKS_PER_BIT cycles. The start bit appears on `uartTx` right after the command edge. The answer is the status from before the command, so busy reads 0.
- R4: Code 0x05 while the transmitter is busy is dropped. The frame in progress continues unchanged, and the answer has busy (bit 0) set.
- R5: Code 0x06 copies the payload to `ledOut` at the command edge and answers 0x00. `ledOut` changes on no other access.
- R6: Code 0x07 answers with the switch inputs in bits 3..0 and zeros in bits 7..4. The switches pass through two flip-flops first, so a value that has been stable across two edges before the command edge is the one returned.
- R7: Any code other than 0x04..0x07 has no side effect and answers 0x00.
- R8: `rspData` changes only on an edge where `cmdValid` is high, and it keeps its value otherwise.
- R9: `uartTx` is high whenever no frame is in progress, and a frame keeps the transmitter busy for exactly 10*CLKS_PER_BIT cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command strobe, one cycle per access |
| cmdAddr | input | 8 | Command code |
| cmdData | input | 8 | Payload byte |
| rspData | output | 8 | Registered answer to the last command |
| rxDataValid | input | 1 | Receive-valid flag from outside, asynchronous |
| uartTx | output | 1 | Serial transmit line, idle high |
| ledOut | output | 8 | LED drive register |
| swIn | input | SW_WIDTH | Switch inputs, asynchronous |

## Verification
The answer and the LED register are due one edge after the strobe. The serial line shows the start bit right after the edge that accepts a send, and advances one bit every CLKS_PER_BIT edges from there. The switch and receive-valid inputs reach an answer only after two edges of synchronisation. The bench drives inputs and samples outputs on the falling edge. Its reference model advances only on rising edges, so each output is compared in the half-cycle after the edge that should have produced it, on every clock.

// File: rtl/io_cmd_hub_pkg.sv
package io_cmd_hub_pkg;

  localparam logic [7:0] CMD_UART_STATUS = 8'h04;
  localparam logic [7:0] CMD_UART_SEND   = 8'h05;
  localparam logic [7:0] CMD_LED_SET     = 8'h06;
  localparam logic [7:0] CMD_SW_READ     = 8'h07;

  typedef enum logic [1:0] {
    RSP_ZERO   = 2'd0,
    RSP_STATUS = 2'd1,
    RSP_SWITCH = 2'd2
  } rspSel_t;

  typedef struct packed {
    logic    respond;
    rspSel_t rspSel;
    logic    txLoad;
    logic    ledLoad;
  } hubStrobe_t;

endpackage

// File: rtl/io_cmd_hub_sync.sv
module io_cmd_hub_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= '0;
      else       stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/io_cmd_hub_uart_tx.sv
module io_cmd_hub_uart_tx #(
  parameter int DATA_W       = 8,
  parameter int CLKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [DATA_W-1:0] loadData,
  output logic              txLine,
  output logic              busy
);

  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   baudCnt;
  logic [IDX_W-1:0]   bitIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frame   <= '1;
      baudCnt <= '0;
      bitIdx  <= '0;
      busy    <= 1'b0;
    end else if (load && !busy) begin
      frame   <= {1'b1, loadData, 1'b0};
      baudCnt <= '0;
      bitIdx  <= '0;
      busy    <= 1'b1;
    end else if (busy) begin
      if (baudCnt == LAST_CNT) begin
        baudCnt <= '0;
        if (bitIdx == LAST_IDX) begin
          busy <= 1'b0;
        end else begin
          bitIdx <= bitIdx + IDX_W'(1);
          frame  <= {1'b1, frame[FRAME_W-1:1]};
        end
      end else begin
        baudCnt <= baudCnt + CNT_W'(1);
      end
    end
  end

  assign txLine = busy ? frame[0] : 1'b1;

endmodule

// File: rtl/io_cmd_hub_ctrl.sv
module io_cmd_hub_ctrl
  import io_cmd_hub_pkg::*;
(
  input  logic       cmdValid,
  input  logic [7:0] cmdAddr,
  input  logic       txBusy,
  output hubStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    if (cmdValid) begin
      strobe.respond = 1'b1;
      case (cmdAddr)
        CMD_UART_STATUS: strobe.rspSel = RSP_STATUS;
        CMD_UART_SEND: begin
          strobe.rspSel = RSP_STATUS;
          strobe.txLoad = !txBusy;
        end
        CMD_LED_SET: begin
          strobe.rspSel  = RSP_ZERO;
          strobe.ledLoad = 1'b1;
        end
        CMD_SW_READ: strobe.rspSel = RSP_SWITCH;
        default:     strobe.rspSel = RSP_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/io_cmd_hub_dp.sv
module io_cmd_hub_dp
  import io_cmd_hub_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int SW_WIDTH     = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int CLKS_PER_BIT = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  hubStrobe_t          strobe,
  input  logic [DATA_W-1:0]   cmdData,
  input  logic                rxDataValid,
  input  logic [SW_WIDTH-1:0] swIn,
  output logic [DATA_W-1:0]   rspData,
  output logic [DATA_W-1:0]   ledOut,
  output logic                uartTx,
  output logic                txBusy
);

  localparam int SYNC_W = SW_WIDTH + 1;

  logic [SYNC_W-1:0]   syncBus;
  logic [SW_WIDTH-1:0] swSync;
  logic                rxSync;
  logic [DATA_W-1:0]   statusWord;
  logic [DATA_W-1:0]   switchWord;

  io_cmd_hub_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({rxDataValid, swIn}),
    .syncOut (syncBus)
  );

  assign {rxSync, swSync} = syncBus;

  io_cmd_hub_uart_tx #(
    .DATA_W       (DATA_W),
    .CLKS_PER_BIT (CLKS_PER_BIT)
  ) u_tx (
    .clk      (clk),
    .rstN     (rstN),
    .load     (strobe.txLoad),
    .loadData (cmdData),
    .txLine   (uartTx),
    .busy     (txBusy)
  );

  assign statusWord = {{(DATA_W-2){1'b0}}, rxSync, txBusy};
  assign switchWord = {{(DATA_W-SW_WIDTH){1'b0}}, swSync};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ledOut <= '0;
    else if (strobe.ledLoad) ledOut <= cmdData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspData <= '0;
    end else if (strobe.respond) begin
      case (strobe.rspSel)
        RSP_STATUS: rspData <= statusWord;
        RSP_SWITCH: rspData <= switchWord;
        default:    rspData <= '0;
      endcase
    end
  end

endmodule

// File: rtl/io_cmd_hub.sv
module io_cmd_hub
  import io_cmd_hub_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int SW_WIDTH     = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic [7:0]          cmdAddr,
  input  logic [7:0]          cmdData,
  output logic [7:0]          rspData,
  input  logic                rxDataValid,
  output logic                uartTx,
  output logic [7:0]          ledOut,
  input  logic [SW_WIDTH-1:0] swIn
);

  hubStrobe_t strobe;
  logic       txBusy;

  io_cmd_hub_ctrl u_ctrl (
    .cmdValid (cmdValid),
    .cmdAddr  (cmdAddr),
    .txBusy   (txBusy),
    .strobe   (strobe)
  );

  io_cmd_hub_dp #(
    .DATA_W       (8),
    .SW_WIDTH     (SW_WIDTH),
    .SYNC_STAGES  (SYNC_STAGES),
    .CLKS_PER_BIT (CLKS_PER_BIT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cmdData     (cmdData),
    .rxDataValid (rxDataValid),
    .swIn        (swIn),
    .rspData     (rspData),
    .ledOut      (ledOut),
    .uartTx      (uartTx),
    .txBusy      (txBusy)
  );

endmodule

// File: rtl/io_cmd_hub_chk.sv
module io_cmd_hub_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [7:0] cmdAddr,
  input logic [7:0] cmdData,
  input logic [7:0] rspData,
  input logic [7:0] ledOut,
  input logic       uartTx,
  input logic       txBusy
);

  assert_unlisted_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdAddr < 8'h04 || cmdAddr > 8'h07)) |=> (rspData == 8'h00));

  assert_led_answer_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdAddr == 8'h06) |=> (rspData == 8'h00));

  assert_led_latch_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdAddr == 8'h06) |=> (ledOut == $past(cmdData)));

  assert_led_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && cmdAddr == 8'h06) |=> $stable(ledOut));

  assert_sw_upper_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdAddr == 8'h07) |=> (rspData[7:4] == 4'h0));

  assert_status_upper_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdAddr == 8'h04 || cmdAddr == 8'h05)) |=> (rspData[7:2] == 6'h00));

  assert_busy_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdAddr == 8'h05 && txBusy) |=> (rspData[0] && txBusy));

  assert_start_bit_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> !uartTx);

  assert_idle_high_R9: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> uartTx);

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> $stable(rspData));

endmodule

bind io_cmd_hub io_cmd_hub_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdAddr  (cmdAddr),
  .cmdData  (cmdData),
  .rspData  (rspData),
  .ledOut   (ledOut),
  .uartTx   (uartTx),
  .txBusy   (txBusy)
);

// File: tb/tb_io_cmd_hub.sv
module tb_io_cmd_hub;

  localparam int CPB = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [7:0] cmdAddr = 8'h00;
  logic [7:0] cmdData = 8'h00;
  logic       rxDataValid = 1'b0;
  logic [3:0] swIn = 4'h0;
  logic [7:0] rspData;
  logic       uartTx;
  logic [7:0] ledOut;

  io_cmd_hub #(.CLKS_PER_BIT(CPB), .SW_WIDTH(4), .SYNC_STAGES(2)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .rspData(rspData), .rxDataValid(rxDataValid),
    .uartTx(uartTx), .ledOut(ledOut), .swIn(swIn)
  );

  always #2 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  string curReq = "R1";
  bit done = 1'b0;

  // reference model state
  bit   frameQ[$];
  int   phase = 0;
  logic [7:0] expRsp = 8'h00;
  logic [7:0] expLed = 8'h00;
  logic       rxS1 = 0, rxS2 = 0;
  logic [3:0] swS1 = 0, swS2 = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      frameQ.delete();
      phase = 0; expRsp = 8'h00; expLed = 8'h00;
      rxS1 = 0; rxS2 = 0; swS1 = 0; swS2 = 0;
    end else begin
      bit oldBusy;
      logic [7:0] stat;
      oldBusy = (frameQ.size() > 0);
      stat = {6'b0, rxS2, oldBusy};
      if (oldBusy) begin
        phase++;
        if (phase == CPB) begin
          phase = 0;
          void'(frameQ.pop_front());
        end
      end
      if (cmdValid) begin
        case (cmdAddr)
          8'h04: expRsp = stat;
          8'h05: begin
            expRsp = stat;
            if (!oldBusy) begin
              frameQ.push_back(1'b0);
              for (int i = 0; i < 8; i++) frameQ.push_back(cmdData[i]);
              frameQ.push_back(1'b1);
              phase = 0;
            end
          end
          8'h06: begin expLed = cmdData; expRsp = 8'h00; end
          8'h07: expRsp = {4'h0, swS2};
          default: expRsp = 8'h00;
        endcase
      end
      rxS2 = rxS1; rxS1 = rxDataValid;
      swS2 = swS1; swS1 = swIn;
    end
  end

  task automatic cmp(string what, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%02h expected=%02h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      logic expTx;
      expTx = (frameQ.size() > 0) ? frameQ[0] : 1'b1;
      cmp("rspData", rspData, expRsp);
      cmp("ledOut", ledOut, expLed);
      cmp("uartTx", {7'b0, uartTx}, {7'b0, expTx});
    end
  end

  task automatic issue(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    cmdValid = 1'b1; cmdAddr = a; cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0; cmdAddr = 8'hA5; cmdData = 8'h5A;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          mismatched++;
          compared++;
          $display("FAIL watchdog: actual=hung expected=finished");
          done = 1'b1;
          $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
          $finish;
        end
      end
    join_none

    // R1: reset values
    curReq = "R1";
    idle(3);
    cmp("reset rspData", rspData, 8'h00);
    cmp("reset uartTx", {7'b0, uartTx}, 8'h01);
    @(negedge clk) rstN = 1'b1;
    idle(2);

    // R2: status with receive flag
    curReq = "R2";
    rxDataValid = 1'b1;
    idle(3);
    issue(8'h04, 8'hFF);
    cmp("R2 status rx", rspData, 8'h02);
    rxDataValid = 1'b0;
    issue(8'h04, 8'h00);  // flag not yet through synchroniser
    idle(3);
    issue(8'h04, 8'h00);

    // R6: switch reads, including a change right before the read
    curReq = "R6";
    swIn = 4'hA; idle(3);
    issue(8'h07, 8'h00);
    cmp("R6 switch", rspData, 8'h0A);
    swIn = 4'h5;
    issue(8'h07, 8'h00);
    issue(8'h07, 8'h00);
    swIn = 4'hF; idle(3);
    issue(8'h07, 8'h33);

    // R5: LED latch
    curReq = "R5";
    issue(8'h06, 8'hA5);
    cmp("R5 led", ledOut, 8'hA5);
    issue(8'h06, 8'h3C);
    issue(8'h04, 8'h77);
    cmp("R5 led held", ledOut, 8'h3C);

    // R7: unlisted codes
    curReq = "R7";
    issue(8'h00, 8'h11);
    issue(8'h03, 8'h22);
    issue(8'h08, 8'h33);
    issue(8'hFF, 8'h44);
    cmp("R7 led untouched", ledOut, 8'h3C);

    // R8: answer holds with no strobe
    curReq = "R8";
    issue(8'h07, 8'h00);
    cmdAddr = 8'h06; cmdData = 8'h99;
    idle(5);
    cmp("R8 hold", rspData, 8'h0F);

    // R3: send a byte, watch the frame
    curReq = "R3";
    issue(8'h05, 8'h5A);
    cmp("R3 accept answer", rspData, 8'h00);
    idle(6);
    curReq = "R2";
    issue(8'h04, 8'h00);
    cmp("R2 busy", rspData[0] ? 8'h01 : 8'h00, 8'h01);

    // R4: send while busy is dropped
    curReq = "R4";
    issue(8'h05, 8'hFF);
    cmp("R4 drop answer", rspData, 8'h01);
    idle(10);
    issue(8'h05, 8'h00);

    // R9: frame end and idle line, then back-to-back send
    curReq = "R9";
    idle(10 * CPB);
    issue(8'h04, 8'h00);
    cmp("R9 idle status", rspData, 8'h00);
    curReq = "R3";
    issue(8'h05, 8'h81);
    curReq = "R9";
    idle(10 * CPB - 3);
    issue(8'h05, 8'hC3);  // arrives in the last busy cycles: dropped
    idle(2);
    curReq = "R3";
    issue(8'h05, 8'h3C);
    idle(10 * CPB + 4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule